// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity Generator/Checker

This block joins two byte-wide bus ports through a transceiver whose direction is set by one control input. In transmit the value seen on port A is passed out on port B, and a parity bit is produced on a shared parity pin. In receive the value seen on port B is passed out on port A. The parity pin then becomes an input, and a check flag reports whether the received byte and the parity bit agree.

An active-low output enable releases every driven pin at once. The block is purely combinational and has no clock or reset. Each three-state pin is modelled as a triple of data in, data out and drive enable, so that the pad ring or a bus fabric can resolve it. The data-out value of each port always carries the opposite port's input. Whether that value actually reaches the pin is decided by its enable alone.

Top module: `bidir_parity_xcvr`

## Requirements
- R1: With `dir_tx`=1 and `oe_n`=0, `b_oe`=1, `a_oe`=0, and `b_o` equals `a_i`.
- R2: With `dir_tx`=0 and `oe_n`=0, `a_oe`=1, `b_oe`=0, and `a_o` equals `b_i`.
- R3: With `oe_n`=1, all four enables (`a_oe`, `b_oe`, `par_oe`, `flag_oe`) are 0 for every value of `dir_tx`, data, select and parity input.
- R4: In transmit with `oe_n`=0, `par_oe`=1 and `par_o` = `odd_sel` XOR (XOR of all bits of `a_i`). So `odd_sel`=1 with an even number of ones on A gives `par_o`=1.
- R5: In transmit, `flag_oe`=0 (the check flag is never driven while sending).
- R6: In receive with `oe_n`=0, `flag_oe`=1 and `flag_o` = NOT(XOR of all bits of `b_i` XOR `odd_sel` XOR `par_i`). A value of 1 means parity is correct.
- R7: In receive, `par_oe`=0, so the parity pin is treated as an input only.
- R8: `par_o` and `flag_o` depend on the data byte only through the parity of its one-count. Two bytes with equal one-count parity give identical parity and flag outputs for the same select and parity input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_tx | input | 1 | 1 = transmit (A to B), 0 = receive (B to A) |
| oe_n | input | 1 | Active-low output enable for all driven pins |
| odd_sel | input | 1 | Parity sense select |
| a_i | input | W | Port A pin value in |
| a_o | output | W | Port A drive value (B input) |
| a_oe | output | 1 | Port A drive enable |
| b_i | input | W | Port B pin value in |
| b_o | output | W | Port B drive value (A input) |
| b_oe | output | 1 | Port B drive enable |
| par_i | input | 1 | Parity pin value in (used in receive) |
| par_o | output | 1 | Generated parity (used in transmit) |
| par_oe | output | 1 | Parity pin drive enable |
| flag_o | output | 1 | Check flag, 1 = parity correct |
| flag_oe | output | 1 | Check flag drive enable |

## Verification
The bench sweeps every byte together with every setting of the select, parity input, direction and enable. A parity sense inverted against the select would flip `par_o` or `flag_o` in half of all vectors. A flag that reads 1 on error rather than on success would fail every receive case. Enables that ignore `oe_n`, or that leave the parity pin driven during receive, would put two drivers on one wire and are caught at the enable outputs. Bytes of all zeros, all ones, and single-bit cases are also checked by name, where a reduction that drops the top or bottom bit would show.

// File: rtl/bpx_pkg.sv
package bpx_pkg;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } bpx_dir_e;

    typedef struct packed {
        logic a_en;
        logic b_en;
        logic par_en;
        logic flag_en;
    } bpx_en_t;

endpackage

// File: rtl/bpx_xor_tree.sv
module bpx_xor_tree #(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    output logic         odd
);
    logic [W-1:0] acc;

    assign acc[0] = d[0];
    for (genvar i = 1; i < W; i++) begin : g_chain
        assign acc[i] = acc[i-1] ^ d[i];
    end

    assign odd = acc[W-1];
endmodule

// File: rtl/bpx_ctrl.sv
module bpx_ctrl
    import bpx_pkg::*;
(
    input  logic    dir_tx,
    input  logic    oe_n,
    output bpx_en_t en
);
    bpx_dir_e dir;

    always_comb begin
        dir = bpx_dir_e'(dir_tx);
        en  = '0;
        if (!oe_n) begin
            if (dir == DIR_TX) begin
                en.b_en   = 1'b1;
                en.par_en = 1'b1;
            end else begin
                en.a_en    = 1'b1;
                en.flag_en = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bidir_parity_xcvr.sv
module bidir_parity_xcvr
    import bpx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         dir_tx,
    input  logic         oe_n,
    input  logic         odd_sel,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] a_o,
    output logic         a_oe,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] b_o,
    output logic         b_oe,
    input  logic         par_i,
    output logic         par_o,
    output logic         par_oe,
    output logic         flag_o,
    output logic         flag_oe
);
    typedef struct packed {
        logic [W-1:0] a_val;
        logic [W-1:0] b_val;
        logic         par;
        logic         flag;
    } out_t;

    bpx_en_t en;
    logic    a_odd;
    logic    b_odd;
    out_t    out_d;

    bpx_ctrl u_ctrl (
        .dir_tx (dir_tx),
        .oe_n   (oe_n),
        .en     (en)
    );

    bpx_xor_tree #(.W(W)) u_tree_a (.d(a_i), .odd(a_odd));
    bpx_xor_tree #(.W(W)) u_tree_b (.d(b_i), .odd(b_odd));

    always_comb begin
        out_d       = '0;
        out_d.a_val = b_i;
        out_d.b_val = a_i;
        out_d.par   = odd_sel ^ a_odd;
        out_d.flag  = ~(b_odd ^ odd_sel ^ par_i);
    end

    assign a_o     = out_d.a_val;
    assign b_o     = out_d.b_val;
    assign par_o   = out_d.par;
    assign flag_o  = out_d.flag;
    assign a_oe    = en.a_en;
    assign b_oe    = en.b_en;
    assign par_oe  = en.par_en;
    assign flag_oe = en.flag_en;
endmodule

// File: rtl/bpx_checker.sv
module bpx_checker #(
    parameter int W = 8
) (
    input logic         dir_tx,
    input logic         oe_n,
    input logic         odd_sel,
    input logic [W-1:0] a_i,
    input logic [W-1:0] a_o,
    input logic         a_oe,
    input logic [W-1:0] b_i,
    input logic [W-1:0] b_o,
    input logic         b_oe,
    input logic         par_i,
    input logic         par_o,
    input logic         par_oe,
    input logic         flag_o,
    input logic         flag_oe
);
    always_comb begin
        AST_TX_DATA_PASS: assert (!(b_oe) || (b_o == a_i && dir_tx)); // R1
        AST_RX_DATA_PASS: assert (!(a_oe) || (a_o == b_i && !dir_tx)); // R2
        AST_QUIET_WHEN_OFF: assert (!oe_n || !(a_oe || b_oe || par_oe || flag_oe)); // R3
        AST_TX_PARITY_EVEN_TOTAL: assert (!par_oe || ((^a_i) ^ par_o ^ odd_sel) == 1'b0); // R4
        AST_NO_FLAG_IN_TX: assert (!dir_tx || !flag_oe); // R5
        AST_RX_FLAG_RULE: assert (!flag_oe || (flag_o == ~((^b_i) ^ odd_sel ^ par_i))); // R6
        AST_NO_PAR_DRIVE_IN_RX: assert (dir_tx || !par_oe); // R7
        AST_SINGLE_DIRECTION: assert (!(a_oe && b_oe)); // R1
    end
endmodule

bind bidir_parity_xcvr bpx_checker #(.W(W)) u_chk (.*);

// File: tb/sim_bidir_parity_xcvr.sv
module sim_bidir_parity_xcvr;
    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         dir_tx, oe_n, odd_sel, par_i;
    logic [W-1:0] a_i, b_i, a_o, b_o;
    logic         a_oe, b_oe, par_o, par_oe, flag_o, flag_oe;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    bidir_parity_xcvr #(.W(W)) u0 (
        .dir_tx(dir_tx), .oe_n(oe_n), .odd_sel(odd_sel),
        .a_i(a_i), .a_o(a_o), .a_oe(a_oe),
        .b_i(b_i), .b_o(b_o), .b_oe(b_oe),
        .par_i(par_i), .par_o(par_o), .par_oe(par_oe),
        .flag_o(flag_o), .flag_oe(flag_oe)
    );

    // vector: {dir, oe_n, sel, par_in, a, b, exp_par, exp_flag}
    typedef struct packed {
        logic       dir;
        logic       oen;
        logic       sel;
        logic       pin;
        logic [7:0] a;
        logic [7:0] b;
        logic       ep;
        logic       ef;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'h80, 8'h00, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 8'h00, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h07, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h80, 1'b0, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b1}
    };

    function automatic int ones(input logic [W-1:0] v);
        int c = 0;
        for (int i = 0; i < W; i++) if (v[i]) c++;
        return c;
    endfunction

    task automatic apply(input logic d, input logic o, input logic s,
                         input logic p, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        dir_tx = d; oe_n = o; odd_sel = s; par_i = p; a_i = a; b_i = b;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h (dir=%0b oe_n=%0b sel=%0b par_i=%0b a=%0h b=%0h)",
                     req, act, exp, dir_tx, oe_n, odd_sel, par_i, a_i, b_i);
        end
    endtask

    // full check of the current inputs against a popcount model
    task automatic model_check();
        logic en, a_even, b_even, ep, ef;
        en     = !oe_n;
        a_even = (ones(a_i) % 2) == 0;
        b_even = (ones(b_i) % 2) == 0;
        ep     = odd_sel ? a_even : !a_even;
        ef     = (odd_sel == par_i) ? b_even : !b_even;
        chk("R3_enables", {a_oe, b_oe, par_oe, flag_oe},
            {en & !dir_tx, en & dir_tx, en & dir_tx, en & !dir_tx});
        chk("R1_b_data", b_o, a_i);
        chk("R2_a_data", a_o, b_i);
        if (dir_tx && en)  chk("R4_parity", par_o, ep);
        if (!dir_tx && en) chk("R6_flag", flag_o, ef);
    endtask

    initial begin
        dir_tx = 1'b0; oe_n = 1'b1; odd_sel = 1'b0; par_i = 1'b0;
        a_i = '0; b_i = '0;
        @(negedge clk);
        // idle state: output enable released, nothing driven (R3)
        chk("R3_idle", {a_oe, b_oe, par_oe, flag_oe}, 4'b0000);

        foreach (VECS[k]) begin
            apply(VECS[k].dir, VECS[k].oen, VECS[k].sel, VECS[k].pin, VECS[k].a, VECS[k].b);
            if (VECS[k].dir) chk("R4_table", par_o, VECS[k].ep);
            else             chk("R6_table", flag_o, VECS[k].ef);
        end

        // exhaustive sweep
        for (int m = 0; m < 16; m++) begin
            for (int v = 0; v < 256; v++) begin
                apply(m[3], m[2], m[1], m[0], v[7:0], 8'(v ^ 8'h5A));
                model_check();
            end
        end

        // R5: flag never driven in transmit, even when enabled
        apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 8'hFF);
        chk("R5_flag_off_tx", flag_oe, 1'b0);
        // R7: parity pin not driven in receive
        apply(1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h01);
        chk("R7_par_off_rx", {par_oe, b_oe}, 2'b00);
        // R3: disable with both directions
        apply(1'b1, 1'b1, 1'b1, 1'b1, 8'hAA, 8'h55);
        chk("R3_off_tx", {a_oe, b_oe, par_oe, flag_oe}, 4'b0000);
        apply(1'b0, 1'b1, 1'b0, 1'b1, 8'hAA, 8'h55);
        chk("R3_off_rx", {a_oe, b_oe, par_oe, flag_oe}, 4'b0000);

        // R8: same class, different bytes, identical outputs
        begin
            logic p1, p2, f1, f2;
            apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h03, 8'h00); p1 = par_o;
            apply(1'b1, 1'b0, 1'b0, 1'b0, 8'hF0, 8'h00); p2 = par_o;
            chk("R8_tx_class", p2, p1);
            apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h01); f1 = flag_o;
            apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hE0); f2 = flag_o;
            chk("R8_rx_class", f2, f1);
        end

        done = 1'b1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (done) begin
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end else if (cycles > 20000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule